// File: doc/BRIEF.md
# External Interrupt Sense Controller

This block takes eight asynchronous interrupt pins from outside the chip and presents eight active-high level requests to a parent interrupt controller. Each pin has its own two-bit sense mode. The four modes are low level, falling edge, rising edge and both edges. Each pin is first brought into the clock domain through a two-flop synchroniser. The block then compares successive synchronised samples to find edges, and records each qualifying edge in a per-line status bit. That bit drives the line's output until software clears it.

Software uses a small 32-bit register port that has a write strobe and a combinational read path. The status register sits at offset 0x10, with bit n for line n. The sense-select register sits at offset 0x14, and line n uses bits [2n+1:2n]. A write of 0 to a status bit clears it, but only on a line in an edge mode. A low-level line shows the inverted synchronised pin directly and ignores clears. A clear is visible to a read in the very next cycle, so a handler that reads back after clearing never sees the request again.

Top module: `ext_irq_sense`

## Requirements
- R1: After reset, the status register (0x10) and the sense-select register (0x14) both read 0, and with every pin held high all outputs are low.
- R2: A write to 0x14 stores the low 16 data bits. Line n's mode is bits [2n+1:2n], encoded as 0 = low level, 1 = falling edge, 2 = rising edge, 3 = both edges. Bits 31:16 read as 0.
- R3: On a line in mode 0, the output and status bit n equal the inverted pin, delayed by two clock edges.
- R4: On a line in mode 1, a high-to-low pin change sets status bit n and output n on the third clock edge after the change. The bit stays set after the pin returns high.
- R5: On a line in mode 2, a low-to-high pin change sets the line on the third clock edge. A high-to-low change does not set it.
- R6: On a line in mode 3, either pin transition sets the line on the third clock edge.
- R7: Writing 0 to status bit n of a line in an edge mode clears the bit. The next read of 0x10, and output n in that same cycle, show it cleared.
- R8: Writing 0 to status bit n of a line in mode 0 has no effect. Output n keeps following the inverted pin.
- R9: Writing 1 to a status bit never sets it.
- R10: When an edge is detected in the same cycle as a clear of that line, the bit stays set.
- R11: Output n always equals bit n of the status register as read at 0x10.
- R12: Reads of any offset other than 0x10 and 0x14 return 0. Writes to other offsets change neither register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pinIn | input | 8 | Asynchronous external interrupt pins |
| busWr | input | 1 | Register write strobe, one cycle per write |
| busAddr | input | 8 | Register byte offset for reads and writes |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Combinational read data for busAddr |
| irqOut | output | 8 | Active-high level requests to the parent controller |

## Verification
A pin change reaches a low-level output on the second clock edge after it is driven, and reaches an edge-mode status bit on the third edge. A register write takes effect on the edge that samples it, so a read or output check in the following cycle already sees the new value. The directed tests wait exactly these edge counts and also check one edge too early, which proves the latency as well as the result. The random phase runs a cycle-based reference model, updated on each rising edge and compared on each falling edge, so every comparison is made half a cycle after the edge that produced the value.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;

  localparam int DATA_W = 32;

  typedef enum logic [1:0] {
    SENSE_LOW  = 2'd0,
    SENSE_FALL = 2'd1,
    SENSE_RISE = 2'd2,
    SENSE_BOTH = 2'd3
  } senseMode_e;

  typedef struct packed {
    logic              senseWr;
    logic              statusWr;
    logic [DATA_W-1:0] wdata;
  } ctrlStrobes_t;

endpackage

// File: rtl/ext_irq_sync.sv
module ext_irq_sync #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] rawIn,
  output logic [WIDTH-1:0] syncCur,
  output logic [WIDTH-1:0] syncPrev
);

  logic [WIDTH-1:0] stageOne;

  // Idle level of an active-low pin is high; reset to it so no spurious edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stageOne <= '1;
      syncCur  <= '1;
      syncPrev <= '1;
    end else begin
      stageOne <= rawIn;
      syncCur  <= stageOne;
      syncPrev <= syncCur;
    end
  end

endmodule

// File: rtl/ext_irq_datapath.sv
module ext_irq_datapath
  import ext_irq_pkg::*;
#(
  parameter int NUM_LINES = 8,
  localparam int SENSE_W  = 2 * NUM_LINES
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] pinIn,
  input  ctrlStrobes_t         strobes,
  output logic [NUM_LINES-1:0] statusView,
  output logic [SENSE_W-1:0]   senseVal,
  output logic [NUM_LINES-1:0] modeHit
);

  logic [NUM_LINES-1:0] syncCur;
  logic [NUM_LINES-1:0] syncPrev;
  logic [NUM_LINES-1:0] statusReg;
  logic [SENSE_W-1:0]   senseReg;

  ext_irq_sync #(.WIDTH(NUM_LINES)) sync_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .rawIn    (pinIn),
    .syncCur  (syncCur),
    .syncPrev (syncPrev)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      senseReg <= '0;
    end else if (strobes.senseWr) begin
      senseReg <= strobes.wdata[SENSE_W-1:0];
    end
  end

  assign senseVal = senseReg;

  for (genvar n = 0; n < NUM_LINES; n++) begin : g_line
    senseMode_e lineMode;
    logic       riseSeen;
    logic       fallSeen;
    logic       edgeMode;
    logic       clearReq;

    assign lineMode = senseMode_e'(senseReg[2*n +: 2]);
    assign riseSeen = syncCur[n] & ~syncPrev[n];
    assign fallSeen = ~syncCur[n] & syncPrev[n];
    assign edgeMode = (lineMode != SENSE_LOW);
    assign clearReq = strobes.statusWr & ~strobes.wdata[n] & edgeMode;

    always_comb begin
      unique case (lineMode)
        SENSE_FALL: modeHit[n] = fallSeen;
        SENSE_RISE: modeHit[n] = riseSeen;
        SENSE_BOTH: modeHit[n] = riseSeen | fallSeen;
        default:    modeHit[n] = 1'b0;
      endcase
    end

    // A detected edge outranks a clear arriving in the same cycle.
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        statusReg[n] <= 1'b0;
      end else if (!edgeMode) begin
        statusReg[n] <= 1'b0;
      end else if (modeHit[n]) begin
        statusReg[n] <= 1'b1;
      end else if (clearReq) begin
        statusReg[n] <= 1'b0;
      end
    end

    assign statusView[n] = edgeMode ? statusReg[n] : ~syncCur[n];
  end

endmodule

// File: rtl/ext_irq_ctrl.sv
module ext_irq_ctrl
  import ext_irq_pkg::*;
#(
  parameter int          NUM_LINES  = 8,
  parameter int          ADDR_W     = 8,
  parameter logic [7:0]  STATUS_OFS = 8'h10,
  parameter logic [7:0]  SENSE_OFS  = 8'h14,
  localparam int         SENSE_W    = 2 * NUM_LINES
) (
  input  logic                 busWr,
  input  logic [ADDR_W-1:0]    busAddr,
  input  logic [DATA_W-1:0]    busWdata,
  input  logic [NUM_LINES-1:0] statusView,
  input  logic [SENSE_W-1:0]   senseVal,
  output ctrlStrobes_t         strobes,
  output logic [DATA_W-1:0]    busRdata
);

  logic hitStatus;
  logic hitSense;

  assign hitStatus = (busAddr == ADDR_W'(STATUS_OFS));
  assign hitSense  = (busAddr == ADDR_W'(SENSE_OFS));

  always_comb begin
    strobes          = '0;
    strobes.statusWr = busWr & hitStatus;
    strobes.senseWr  = busWr & hitSense;
    strobes.wdata    = busWdata;
  end

  always_comb begin
    busRdata = '0;
    if (hitStatus) begin
      busRdata[NUM_LINES-1:0] = statusView;
    end else if (hitSense) begin
      busRdata[SENSE_W-1:0] = senseVal;
    end
  end

endmodule

// File: rtl/ext_irq_sense.sv
module ext_irq_sense
  import ext_irq_pkg::*;
#(
  parameter int         NUM_LINES  = 8,
  parameter int         ADDR_W     = 8,
  parameter logic [7:0] STATUS_OFS = 8'h10,
  parameter logic [7:0] SENSE_OFS  = 8'h14
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] pinIn,
  input  logic                 busWr,
  input  logic [ADDR_W-1:0]    busAddr,
  input  logic [31:0]          busWdata,
  output logic [31:0]          busRdata,
  output logic [NUM_LINES-1:0] irqOut
);

  localparam int SENSE_W = 2 * NUM_LINES;

  ctrlStrobes_t         strobes;
  logic [NUM_LINES-1:0] statusView;
  logic [SENSE_W-1:0]   senseVal;
  logic [NUM_LINES-1:0] modeHit;

  ext_irq_ctrl #(
    .NUM_LINES  (NUM_LINES),
    .ADDR_W     (ADDR_W),
    .STATUS_OFS (STATUS_OFS),
    .SENSE_OFS  (SENSE_OFS)
  ) ctrl_i (
    .busWr      (busWr),
    .busAddr    (busAddr),
    .busWdata   (busWdata),
    .statusView (statusView),
    .senseVal   (senseVal),
    .strobes    (strobes),
    .busRdata   (busRdata)
  );

  ext_irq_datapath #(.NUM_LINES(NUM_LINES)) dp_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .pinIn      (pinIn),
    .strobes    (strobes),
    .statusView (statusView),
    .senseVal   (senseVal),
    .modeHit    (modeHit)
  );

  assign irqOut = statusView;

endmodule

// File: rtl/ext_irq_sense_chk.sv
module ext_irq_sense_chk #(
  parameter int         NUM_LINES  = 8,
  parameter int         ADDR_W     = 8,
  parameter logic [7:0] STATUS_OFS = 8'h10,
  parameter logic [7:0] SENSE_OFS  = 8'h14,
  localparam int        SENSE_W    = 2 * NUM_LINES
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 busWr,
  input logic [ADDR_W-1:0]    busAddr,
  input logic [31:0]          busWdata,
  input logic [31:0]          busRdata,
  input logic [NUM_LINES-1:0] irqOut,
  input logic [SENSE_W-1:0]   senseVal,
  input logic [NUM_LINES-1:0] modeHit
);

  logic [NUM_LINES-1:0] edgeMask;
  logic                 statWr;
  logic                 senseWrNow;
  logic [NUM_LINES-1:0] clrMask;
  logic [NUM_LINES-1:0] setMask;
  logic [NUM_LINES-1:0] keepMask;

  always_comb begin
    for (int n = 0; n < NUM_LINES; n++) begin
      edgeMask[n] = (senseVal[2*n +: 2] != 2'd0);
    end
  end

  assign statWr     = busWr && (busAddr == ADDR_W'(STATUS_OFS));
  assign senseWrNow = busWr && (busAddr == ADDR_W'(SENSE_OFS));
  assign clrMask    = statWr ? (~busWdata[NUM_LINES-1:0] & edgeMask & ~modeHit) : '0;
  assign setMask    = senseWrNow ? '0 : (modeHit & edgeMask);
  assign keepMask   = statWr ? (busWdata[NUM_LINES-1:0] & edgeMask & ~modeHit & ~irqOut) : '0;

  AST_STATUS_MIRRORS_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    (busAddr == ADDR_W'(STATUS_OFS)) |-> (busRdata[NUM_LINES-1:0] == irqOut)); // R11

  AST_SENSE_WRITE_STORED: assert property (@(posedge clk) disable iff (!rst_n)
    senseWrNow |=> (senseVal == $past(busWdata[SENSE_W-1:0]))); // R2

  AST_EDGE_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (clrMask != '0) |=> ((irqOut & $past(clrMask)) == '0)); // R7

  AST_EDGE_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (setMask != '0) |=> ((irqOut & $past(setMask)) == $past(setMask))); // R10

  AST_ONE_NEVER_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (keepMask != '0) |=> ((irqOut & $past(keepMask)) == '0)); // R9

  AST_UNMAPPED_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    ((busAddr != ADDR_W'(STATUS_OFS)) && (busAddr != ADDR_W'(SENSE_OFS))) |-> (busRdata == '0)); // R12

endmodule

bind ext_irq_sense ext_irq_sense_chk #(
  .NUM_LINES  (NUM_LINES),
  .ADDR_W     (ADDR_W),
  .STATUS_OFS (STATUS_OFS),
  .SENSE_OFS  (SENSE_OFS)
) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .busWr    (busWr),
  .busAddr  (busAddr),
  .busWdata (busWdata),
  .busRdata (busRdata),
  .irqOut   (irqOut),
  .senseVal (senseVal),
  .modeHit  (modeHit)
);

// File: tb/ext_irq_sense_tb_top.sv
`timescale 1ns/1ps
module ext_irq_sense_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  pinIn = 8'hFF;
  logic        busWr = 1'b0;
  logic [7:0]  busAddr = 8'h00;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic [7:0]  irqOut;

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  ext_irq_sense dut_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .pinIn    (pinIn),
    .busWr    (busWr),
    .busAddr  (busAddr),
    .busWdata (busWdata),
    .busRdata (busRdata),
    .irqOut   (irqOut)
  );

  // Reference model, built from the requirements.
  logic [7:0]  mS1, mCur, mPrev, mStat;
  logic [15:0] mSense;

  function automatic logic [7:0] expView(logic [15:0] sense, logic [7:0] stat, logic [7:0] cur);
    logic [7:0] v;
    for (int n = 0; n < 8; n++) begin
      v[n] = (sense[2*n +: 2] == 2'd0) ? ~cur[n] : stat[n];
    end
    return v;
  endfunction

  function automatic logic [31:0] expRead(logic [7:0] addr);
    if (addr == 8'h10) return {24'd0, expView(mSense, mStat, mCur)};
    if (addr == 8'h14) return {16'd0, mSense};
    return 32'd0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mS1 <= 8'hFF; mCur <= 8'hFF; mPrev <= 8'hFF;
      mStat <= 8'h00; mSense <= 16'h0000;
    end else begin
      logic [7:0] nextStat;
      for (int n = 0; n < 8; n++) begin
        logic [1:0] md;
        logic rise, fall, hit, clr;
        md   = mSense[2*n +: 2];
        rise = mCur[n] & ~mPrev[n];
        fall = ~mCur[n] & mPrev[n];
        hit  = (md == 2'd1) ? fall : (md == 2'd2) ? rise : (md == 2'd3) ? (rise | fall) : 1'b0;
        clr  = busWr && (busAddr == 8'h10) && !busWdata[n] && (md != 2'd0);
        nextStat[n] = (md == 2'd0) ? 1'b0 : hit ? 1'b1 : clr ? 1'b0 : mStat[n];
      end
      mStat <= nextStat;
      if (busWr && busAddr == 8'h14) mSense <= busWdata[15:0];
      mS1 <= pinIn; mCur <= mS1; mPrev <= mCur;
    end
  end

  task automatic check(string tag, logic [31:0] actual, logic [31:0] expected);
    testsRun++;
    if (actual !== expected) begin
      testsFailed++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, actual, expected);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic regWrite(logic [7:0] addr, logic [31:0] data);
    busWr = 1'b1; busAddr = addr; busWdata = data;
    @(posedge clk);
    @(negedge clk);
    busWr = 1'b0;
  endtask

  task automatic regRead(logic [7:0] addr, output logic [31:0] data);
    busAddr = addr;
    #0.5;
    data = busRdata;
  endtask

  initial begin
    logic [31:0] rd;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    cyc(2);

    // R1 reset state
    regRead(8'h10, rd); check("R1 status after reset", rd, 32'h0);
    regRead(8'h14, rd); check("R1 sense after reset", rd, 32'h0);
    check("R1 outputs after reset", {24'd0, irqOut}, 32'h0);

    // R2 field layout and readback
    regWrite(8'h14, 32'hABCD_E4C9);
    regRead(8'h14, rd); check("R2 sense readback", rd, 32'h0000_E4C9);
    // line0 falling, line1 rising, line2 both, others low level
    regWrite(8'h14, 32'h0000_0039);
    regRead(8'h14, rd); check("R2 sense program", rd, 32'h0000_0039);

    // R3 low level follows pin with two-edge latency
    pinIn[3] = 1'b0;
    cyc(1); check("R3 one edge early", {31'd0, irqOut[3]}, 32'd0);
    cyc(1); check("R3 asserted", {31'd0, irqOut[3]}, 32'd1);
    pinIn[3] = 1'b1;
    cyc(2); check("R3 released", {31'd0, irqOut[3]}, 32'd0);

    // R4 falling edge
    pinIn[0] = 1'b0;
    cyc(2); check("R4 two edges early", {31'd0, irqOut[0]}, 32'd0);
    cyc(1); check("R4 set", {31'd0, irqOut[0]}, 32'd1);
    pinIn[0] = 1'b1;
    cyc(4); check("R4 latched", {31'd0, irqOut[0]}, 32'd1);

    // R5 rising edge only
    pinIn[1] = 1'b0;
    cyc(4); check("R5 falling ignored", {31'd0, irqOut[1]}, 32'd0);
    pinIn[1] = 1'b1;
    cyc(2); check("R5 two edges early", {31'd0, irqOut[1]}, 32'd0);
    cyc(1); check("R5 set", {31'd0, irqOut[1]}, 32'd1);

    // R6 both edges, R7 clear on an edge line
    pinIn[2] = 1'b0;
    cyc(3); check("R6 falling sets", {31'd0, irqOut[2]}, 32'd1);
    regWrite(8'h10, 32'hFFFF_FFFB);
    regRead(8'h10, rd); check("R7 cleared at read", {31'd0, rd[2]}, 32'd0);
    check("R7 output dropped", {31'd0, irqOut[2]}, 32'd0);
    pinIn[2] = 1'b1;
    cyc(3); check("R6 rising sets", {31'd0, irqOut[2]}, 32'd1);

    // R7 line0
    regWrite(8'h10, 32'hFFFF_FFFE);
    regRead(8'h10, rd); check("R7 line0 cleared", {31'd0, rd[0]}, 32'd0);
    check("R7 line0 output", {31'd0, irqOut[0]}, 32'd0);

    // R10 edge coincident with clear
    pinIn[0] = 1'b0;
    cyc(2);
    regWrite(8'h10, 32'hFFFF_FFFE);
    check("R10 edge wins", {31'd0, irqOut[0]}, 32'd1);
    regWrite(8'h10, 32'hFFFF_FFFE);
    check("R10 later clear works", {31'd0, irqOut[0]}, 32'd0);

    // R8 clear ignored on level line
    pinIn[3] = 1'b0;
    cyc(2);
    regWrite(8'h10, 32'h0000_0000);
    regRead(8'h10, rd); check("R8 level status kept", {31'd0, rd[3]}, 32'd1);
    check("R8 level output kept", {31'd0, irqOut[3]}, 32'd1);
    pinIn[3] = 1'b1;
    cyc(2);

    // R9 writing ones never sets
    regWrite(8'h10, 32'hFFFF_FFFF);
    regRead(8'h10, rd); check("R9 ones write", rd, 32'h0);

    // R12 unmapped offsets
    regRead(8'h18, rd); check("R12 unmapped read", rd, 32'h0);
    regWrite(8'h18, 32'hFFFF_FFFF);
    regRead(8'h14, rd); check("R12 sense untouched", rd, 32'h0000_0039);
    regRead(8'h10, rd); check("R12 status untouched", rd, 32'h0);

    // Random phase against the model (R3..R7, R11)
    for (int i = 0; i < 3000; i++) begin
      check("R11 random output", {24'd0, irqOut}, {24'd0, expView(mSense, mStat, mCur)});
      check("R7 random read", busRdata, expRead(busAddr));
      if (($urandom % 4) == 0) pinIn[$urandom % 8] ^= 1'b1;
      if (($urandom % 6) == 0) begin
        busWr = 1'b1;
        case ($urandom % 5)
          0: busAddr = 8'h14;
          1: busAddr = 8'h18;
          default: busAddr = 8'h10;
        endcase
        busWdata = $urandom;
      end else begin
        busWr = 1'b0;
        busAddr = (($urandom % 2) == 0) ? 8'h10 : 8'h14;
      end
      @(posedge clk);
      @(negedge clk);
    end
    busWr = 1'b0;

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    #(5.0 * 20000);
    if (!finished) begin
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog (all requirements) actual=timeout expected=done");
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

endmodule